// File: doc/BRIEF.md
# Serial Attenuator Control Receiver

This block is the digital control front end of a multi-channel stepped audio attenuator. A host drives three wires: a serial clock, an active-low shift enable and a serial data line. While the enable is low, each rising edge of the serial clock moves one data bit into a 16-bit frame register. The bit pushed out of the far end of that register appears on a serial output, so several receivers can share one data line in a chain. When the enable returns high, the register is taken as a frame made of a channel-select byte and a level byte. Only the selected channel's setting is then rewritten.

All three control wires are asynchronous to the system clock. Each passes through a synchronizer, and edges are detected after synchronization. The level byte follows a piecewise scale. Low codes step in half-dB increments and middle codes in whole-dB increments. Every code from 0x7F upward mutes the channel. Each channel reports its attenuation as an 8-bit count of half-dB units, together with a separate mute flag. The frame length is not checked: a frame cut short is decoded from whatever the register holds when the enable rises.

Top module: `atten_ctrl_rx`

## Requirements
- R1: A frame bit is taken from the data input on each rising edge of the serial clock while the enable is low. Serial clock edges while the enable is high leave the frame register and the serial output unchanged.
- R2: The first bit shifted in ends up as register bit 15. After 16 shifts, bits 15..8 hold the channel-select byte (sent first, MSB first) and bits 7..0 hold the level byte (sent second, MSB first).
- R3: The serial output always shows register bit 15, which is the oldest bit held. When the next frame is shifted in, a previous frame leaves the serial output MSB first.
- R4: A rising edge of the enable decodes the register contents. The channel outputs change on the third system clock rising edge at which the enable input is sampled high, and not before.
- R5: Select byte value n, for n below the channel count, updates only channel n (0x00 selects channel 0, 0x01 selects channel 1). Any other select value leaves every channel unchanged, and the unselected channels keep their setting.
- R6: Level codes 0x00 to 0x5F clear the mute flag and set the attenuation output equal to the code (code × 0.5 dB).
- R7: Level codes 0x60 to 0x7E clear the mute flag and set the attenuation output to 2 × code − 96 half-dB units (48 dB to 78 dB in 1 dB steps).
- R8: Level codes 0x7F to 0xFF set the mute flag, and the attenuation output reads 200 half-dB units (100 dB).
- R9: After reset every channel is muted with attenuation 200, and the serial output is 0.
- R10: If the enable rises after fewer than 16 shifts, the register is decoded exactly as it stands. Older bits fill the select byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_en_n_i | input | 1 | Shift enable, active low, asynchronous; its rising edge loads the frame |
| ser_dat_i | input | 1 | Serial data in |
| ser_dat_o | output | 1 | Serial data out toward the next receiver in the chain |
| atten_o | output | 8*NUM_CH | Attenuation per channel in half-dB units, channel 0 in bits 7..0 |
| mute_o | output | NUM_CH | Mute flag per channel |

## Verification
The bench builds the receiver with two channels and a two-stage synchronizer. With two channels, select values 0x00 and 0x01 are valid and 0x02 and above are out of range, so both the update path and the ignore path are exercised. With two sync stages, the exact latency from the enable edge can be checked cycle by cycle against a behavioural model. Level codes at each end of the three decode ranges are sent, as are a 32-bit chained transfer and a truncated 8-bit frame.

// File: rtl/atten_pkg.sv
package atten_pkg;
    localparam int ADDR_W      = 8;
    localparam int LVL_W       = 8;
    localparam int FRAME_W     = ADDR_W + LVL_W;
    localparam int ATT_W       = 8;
    localparam logic [LVL_W-1:0] FULL_FIRST = 8'h60;
    localparam logic [LVL_W-1:0] MUTE_FIRST = 8'h7F;
    localparam logic [ATT_W-1:0] HALF_OFFS  = 8'd96;
    localparam logic [ATT_W-1:0] MUTE_ATT   = 8'd200;

    typedef struct packed {
        logic             mute;
        logic [ATT_W-1:0] att;
    } lvl_dec_t;

    function automatic lvl_dec_t decode_lvl(input logic [LVL_W-1:0] code);
        lvl_dec_t r;
        if (code >= MUTE_FIRST) begin
            r.mute = 1'b1;
            r.att  = MUTE_ATT;
        end else if (code >= FULL_FIRST) begin
            r.mute = 1'b0;
            r.att  = {code[ATT_W-2:0], 1'b0} - HALF_OFFS;
        end else begin
            r.mute = 1'b0;
            r.att  = code;
        end
        return r;
    endfunction
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/atten_shift.sv
module atten_shift
    import atten_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_ev,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frame_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_ev) sh_d.frame = {sh_q.frame[FRAME_W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign frame_o = sh_q.frame;
endmodule

// File: rtl/atten_chan_bank.sv
module atten_chan_bank
    import atten_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    latch_ev,
    input  logic [FRAME_W-1:0]      frame_i,
    output logic [NUM_CH*ATT_W-1:0] atten_o,
    output logic [NUM_CH-1:0]       mute_o
);
    typedef struct packed {
        logic [NUM_CH-1:0]            mute;
        logic [NUM_CH-1:0][ATT_W-1:0] att;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [ADDR_W-1:0] sel;
    lvl_dec_t          dec;

    assign sel = frame_i[FRAME_W-1 -: ADDR_W];
    assign dec = decode_lvl(frame_i[LVL_W-1:0]);

    always_comb begin
        bk_d = bk_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (latch_ev && sel == ADDR_W'(c)) begin
                bk_d.mute[c] = dec.mute;
                bk_d.att[c]  = dec.att;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q.mute <= '1;
            for (int c = 0; c < NUM_CH; c++) bk_q.att[c] <= MUTE_ATT;
        end else begin
            bk_q <= bk_d;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_out
        assign atten_o[c*ATT_W +: ATT_W] = bk_q.att[c];
    end
    assign mute_o = bk_q.mute;
endmodule

// File: rtl/atten_ctrl_rx.sv
module atten_ctrl_rx
    import atten_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_clk_i,
    input  logic                    ser_en_n_i,
    input  logic                    ser_dat_i,
    output logic                    ser_dat_o,
    output logic [NUM_CH*ATT_W-1:0] atten_o,
    output logic [NUM_CH-1:0]       mute_o
);
    // synchronized vector order: {enable, clock, data}
    localparam logic [2:0] SYNC_RST = 3'b100;

    typedef struct packed {
        logic clk_prev;
        logic en_prev;
    } edge_t;

    logic [2:0]         sync_v;
    logic               s_clk, s_en, s_dat;
    logic               shift_ev, latch_ev;
    logic [FRAME_W-1:0] frame_q;
    edge_t              ed_d, ed_q;

    atten_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_en_n_i, ser_clk_i, ser_dat_i}),
        .q_o   (sync_v)
    );

    assign {s_en, s_clk, s_dat} = sync_v;

    always_comb begin
        ed_d.clk_prev = s_clk;
        ed_d.en_prev  = s_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ed_q <= '{clk_prev: 1'b0, en_prev: 1'b1};
        else        ed_q <= ed_d;
    end

    assign shift_ev = s_clk & ~ed_q.clk_prev & ~s_en;
    assign latch_ev = s_en & ~ed_q.en_prev;

    atten_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_ev (shift_ev),
        .bit_i    (s_dat),
        .frame_o  (frame_q)
    );

    atten_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_ev (latch_ev),
        .frame_i  (frame_q),
        .atten_o  (atten_o),
        .mute_o   (mute_o)
    );

    assign ser_dat_o = frame_q[FRAME_W-1];
endmodule

// File: rtl/atten_ctrl_rx_chk.sv
module atten_ctrl_rx_chk
    import atten_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    shift_ev,
    input logic                    latch_ev,
    input logic [FRAME_W-1:0]      frame_q,
    input logic                    ser_dat_o,
    input logic [NUM_CH*ATT_W-1:0] atten_o,
    input logic [NUM_CH-1:0]       mute_o
);
    // R9
    reset_muted_chk: assert property (@(posedge clk) !rst_n |=> (&mute_o && !ser_dat_o));

    // R1
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_ev |=> $stable(frame_q));

    // R3
    ser_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ev |=> ser_dat_o == $past(frame_q[FRAME_W-2]));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R5
        unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!latch_ev || frame_q[FRAME_W-1 -: ADDR_W] != ADDR_W'(c)) |=>
            ($stable(atten_o[c*ATT_W +: ATT_W]) && $stable(mute_o[c])));

        // R6
        half_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_ev && frame_q[FRAME_W-1 -: ADDR_W] == ADDR_W'(c) && frame_q[7:0] < 8'h60) |=>
            (!mute_o[c] && atten_o[c*ATT_W +: ATT_W] == $past(frame_q[7:0])));

        // R7
        full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_ev && frame_q[FRAME_W-1 -: ADDR_W] == ADDR_W'(c) &&
             frame_q[7:0] >= 8'h60 && frame_q[7:0] < 8'h7F) |=>
            (!mute_o[c] && atten_o[c*ATT_W +: ATT_W] >= 8'd96 && atten_o[c*ATT_W +: ATT_W] <= 8'd156));

        // R8
        mute_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mute_o[c] |-> atten_o[c*ATT_W +: ATT_W] == 8'd200);
    end
endmodule

bind atten_ctrl_rx atten_ctrl_rx_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_ev  (shift_ev),
    .latch_ev  (latch_ev),
    .frame_q   (frame_q),
    .ser_dat_o (ser_dat_o),
    .atten_o   (atten_o),
    .mute_o    (mute_o)
);

// File: tb/tb_atten_ctrl_rx.sv
module tb_atten_ctrl_rx;
    localparam int NCH = 2;
    localparam int SS  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_en_n = 1'b1;
    logic ser_dat = 1'b0;
    logic ser_out;
    logic [NCH*8-1:0] atten;
    logic [NCH-1:0] mute;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [15:0] cap = '0;

    always #5 clk = ~clk;

    atten_ctrl_rx #(.NUM_CH(NCH), .SYNC_STAGES(SS)) dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_en_n_i(ser_en_n),
        .ser_dat_i(ser_dat), .ser_dat_o(ser_out), .atten_o(atten), .mute_o(mute)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_att(input int code);
        if (code >= 127) return 200;
        if (code >= 96) return 96 + (code - 96) * 2;
        return code;
    endfunction

    // behavioural reference model
    bit hc[$], he[$], hd[$];
    bit [15:0] m_sr;
    int m_att[NCH];
    bit m_mu[NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            hc = '{};
            he = '{};
            hd = '{};
            for (int i = 0; i <= SS; i++) begin
                hc.push_back(1'b0);
                he.push_back(1'b1);
                hd.push_back(1'b0);
            end
            m_sr = '0;
            for (int i = 0; i < NCH; i++) begin
                m_att[i] = 200;
                m_mu[i] = 1'b1;
            end
        end else begin
            if (hc[SS-1] && !hc[SS] && !he[SS-1]) begin
                m_sr = {m_sr[14:0], hd[SS-1]};
            end else if (he[SS-1] && !he[SS]) begin
                if (int'(m_sr[15:8]) < NCH) begin
                    m_att[m_sr[15:8]] = exp_att(int'(m_sr[7:0]));
                    m_mu[m_sr[15:8]]  = (m_sr[7:0] >= 8'h7F);
                end
            end
            hc.push_front(ser_clk); void'(hc.pop_back());
            he.push_front(ser_en_n); void'(he.pop_back());
            hd.push_front(ser_dat); void'(hd.pop_back());
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 serial out vs model", int'(ser_out), int'(m_sr[15]));
            for (int i = 0; i < NCH; i++) begin
                chk("R5 atten vs model", int'(atten[i*8 +: 8]), m_att[i]);
                chk("R8 mute vs model", int'(mute[i]), int'(m_mu[i]));
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic shift_bits(input logic [15:0] v, input int n);
        ser_en_n = 1'b0;
        step(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            step(4);
            cap = {cap[14:0], ser_out};
            ser_clk = 1'b1;
            step(4);
            ser_clk = 1'b0;
            step(4);
        end
    endtask

    task automatic load();
        ser_en_n = 1'b1;
        step(8);
    endtask

    task automatic frame(input logic [7:0] a, input logic [7:0] l);
        shift_bits({a, l}, 16);
        load();
    endtask

    task automatic chk_ch(input string req, input int ch, input int att, input int mu);
        chk(req, int'(atten[ch*8 +: 8]), att);
        chk(req, int'(mute[ch]), mu);
    endtask

    initial begin
        step(4);
        // R9 reset state
        chk_ch("R9 ch0", 0, 200, 1);
        chk_ch("R9 ch1", 1, 200, 1);
        chk("R9 serial out", int'(ser_out), 0);
        rst_n = 1'b1;
        step(4);

        frame(8'h00, 8'h00);
        chk_ch("R6 ch0 code 0x00", 0, 0, 0);
        chk_ch("R5 ch1 untouched", 1, 200, 1);
        frame(8'h01, 8'h5F);
        chk_ch("R6 ch1 code 0x5F", 1, 95, 0);
        chk_ch("R5 ch0 kept", 0, 0, 0);
        frame(8'h00, 8'h60);
        chk_ch("R7 ch0 code 0x60", 0, 96, 0);
        frame(8'h00, 8'h7E);
        chk_ch("R7 ch0 code 0x7E", 0, 156, 0);
        frame(8'h01, 8'h61);
        chk_ch("R7 ch1 code 0x61", 1, 98, 0);
        frame(8'h00, 8'h7F);
        chk_ch("R8 ch0 code 0x7F", 0, 200, 1);
        frame(8'h01, 8'hFF);
        chk_ch("R8 ch1 code 0xFF", 1, 200, 1);
        frame(8'h01, 8'h22);
        frame(8'h01, 8'h80);
        chk_ch("R8 ch1 code 0x80", 1, 200, 1);
        frame(8'h00, 8'h2A);
        frame(8'h02, 8'h10);
        chk_ch("R5 addr 0x02 ch0", 0, 42, 0);
        chk_ch("R5 addr 0x02 ch1", 1, 200, 1);
        frame(8'hFF, 8'h00);
        chk_ch("R5 addr 0xFF ch0", 0, 42, 0);

        // R1: serial clock pulses with enable high are ignored
        frame(8'h80, 8'h05);
        chk("R1 before pulses", int'(ser_out), 1);
        for (int k = 0; k < 3; k++) begin
            ser_dat = 1'b0;
            step(4);
            ser_clk = 1'b1;
            step(4);
            ser_clk = 1'b0;
            step(4);
        end
        chk("R1 out after ignored pulses", int'(ser_out), 1);
        chk_ch("R1 ch0 after ignored pulses", 0, 42, 0);

        // R3 / R2: chained transfer, previous frame exits MSB first
        shift_bits(16'h00A5, 16);
        shift_bits(16'h0133, 16);
        chk("R3 chained bits out", int'(cap), 16'h00A5);
        load();
        chk_ch("R2 second frame applied ch1", 1, 51, 0);
        chk_ch("R2 ch0 kept", 0, 42, 0);

        // R10: short frame; low byte of old register becomes select
        frame(8'h01, 8'h00);
        shift_bits(16'h0014, 8);
        load();
        chk_ch("R10 short frame ch0", 0, 20, 0);
        chk_ch("R10 short frame ch1", 1, 0, 0);

        // R4: update latency after enable rise
        shift_bits({8'h00, 8'h02}, 16);
        step(2);
        @(posedge clk);
        #2 ser_en_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R4 not yet updated", int'(atten[7:0]), 20);
        end
        @(negedge clk);
        chk("R4 updated on third edge", int'(atten[7:0]), 2);
        step(4);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule